// File: doc/BRIEF.md
# Acquisition Front-End Power Mode Controller

This block decides the power state of a multi-channel acquisition front end. It holds one power-down bit per channel in a configuration register, and a host writes that register through a simple write strobe. It also watches a master clock for rising edges. All of its logic runs on a free-running reference clock. From the register and from the state of the clock it picks one of three modes: normal, register-commanded power-down, or clock-loss power-down. It drives a per-channel enable, a per-channel output enable for the tri-state drivers, and a 2-bit mode code.

The master clock is brought in through a two-flop synchronizer. Every rising edge that is detected restarts a watchdog count. When the count reaches `TIMEOUT` reference cycles with no edge, the block falls into clock-loss mode. In that mode every channel is off whatever the register holds. The register keeps its contents and ignores writes, because the serial side is asleep. When edges return, the block leaves clock-loss mode only after two edges in a row that are each closer together than the timeout. It then goes back to the mode the retained bits select. After reset the block starts in clock-loss mode, since the master clock is taken to be off at that point.

There is no data stream through this block: every pin is a plain control or status level.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no master-clock edges, `mode_o` is 2'b10, `ch_en` and `ch_oe` are all zero and `cfg_q` is all zero.
- R2: With the master clock running and every `cfg_q` bit 0, `mode_o` is 2'b00 and every bit of `ch_en` and `ch_oe` is 1.
- R3: With the master clock running, channel i has `ch_en[i]` = `ch_oe[i]` = NOT `cfg_q[i]`, where a 1 bit means powered down. `mode_o` is 2'b01 when at least one bit is set. `ch_oe` always equals `ch_en`.
- R4: Outside clock-loss mode, a cycle with `cfg_wr` high loads `cfg_wdata` into `cfg_q`, and the new value is visible after that reference-clock edge.
- R5: When no rising master-clock edge is seen for `TIMEOUT` reference cycles, `mode_o` becomes 2'b10 and all `ch_en`/`ch_oe` bits go to 0, whatever `cfg_q` holds. While edges keep arriving, this mode is never entered.
- R6: In clock-loss mode, writes are ignored and `cfg_q` keeps its value. Only reset clears it.
- R7: The block leaves clock-loss mode after two consecutive detected rising edges with fewer than `TIMEOUT` cycles between them. It then enters 2'b00 or 2'b01 according to the retained `cfg_q`.
- R8: A single isolated master-clock edge, followed by a gap of at least `TIMEOUT` cycles, does not take the block out of clock-loss mode.
- R9: `mode_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk | input | 1 | Monitored master clock, asynchronous to ref_clk |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | NCH | Power-down bits to write, 1 = channel off |
| cfg_q | output | NCH | Retained power-down register contents |
| ch_en | output | NCH | Per-channel enable |
| ch_oe | output | NCH | Per-channel output enable, 0 = high impedance |
| mode_o | output | 2 | 00 normal, 01 register power-down, 10 clock-loss |

## Verification
The bench runs several kinds of master-clock activity. A steady clock must never trip the watchdog. A stopped clock must trip it inside a window around `TIMEOUT`, which separates a premature timeout from a missing one. Single pulses spaced wider than the timeout check that recovery needs two close edges and not just one. A restarted clock shows that recovery happens and that it lands in the mode the retained bits select. Under a running clock, random write patterns on a fixed seed compare the enables and the mode code against a model of the per-channel bits. Writes issued during clock loss check that the register kept its old value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_REGPD   = 2'b01,
    MODE_CLKLOSS = 2'b10
  } pmc_mode_e;
endpackage

// File: rtl/pmc_edge_sync.sv
// Brings the master clock into the reference domain and flags rising edges.
module pmc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pmc_watchdog.sv
// Counts reference cycles since the last detected edge; saturates at TIMEOUT.
module pmc_watchdog #(
  parameter int TIMEOUT = 400,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired_o
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= LIMIT;
    else if (kick)           cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pmc_mode_fsm.sv
// Tracks whether the master clock is considered alive.
module pmc_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic expired,
  output logic clk_ok_o
);
  logic clk_ok_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_ok_q <= 1'b0;
      armed_q  <= 1'b0;
    end else if (clk_ok_q) begin
      armed_q <= 1'b0;
      if (expired && !rise) clk_ok_q <= 1'b0;
    end else begin
      if (rise) begin
        if (armed_q) begin
          clk_ok_q <= 1'b1;
          armed_q  <= 1'b0;
        end else begin
          armed_q <= 1'b1;
        end
      end else if (expired) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign clk_ok_o = clk_ok_q;
endmodule

// File: rtl/pmc_cfg_reg.sv
// Per-channel power-down bits; writable only while the clock is alive.
module pmc_cfg_reg #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_allow,
  input  logic           wr,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] bits_o
);
  logic [NCH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              bits_q <= '0;
    else if (wr && wr_allow) bits_q <= wdata;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int TIMEOUT     = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic           mclk,
  input  logic           cfg_wr,
  input  logic [NCH-1:0] cfg_wdata,
  output logic [NCH-1:0] cfg_q,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] ch_oe,
  output logic [1:0]     mode_o
);
  logic      rise;
  logic      expired;
  logic      clk_ok;
  pmc_mode_e mode;

  pmc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .async_in(mclk), .rise_o(rise)
  );

  pmc_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk(ref_clk), .rst_n(rst_n), .kick(rise), .expired_o(expired)
  );

  pmc_mode_fsm u_fsm (
    .clk(ref_clk), .rst_n(rst_n), .rise(rise), .expired(expired),
    .clk_ok_o(clk_ok)
  );

  pmc_cfg_reg #(.NCH(NCH)) u_cfg (
    .clk(ref_clk), .rst_n(rst_n), .wr_allow(clk_ok), .wr(cfg_wr),
    .wdata(cfg_wdata), .bits_o(cfg_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign ch_en[i] = clk_ok & ~cfg_q[i];
    assign ch_oe[i] = clk_ok & ~cfg_q[i];
  end

  always_comb begin
    if (!clk_ok)         mode = MODE_CLKLOSS;
    else if (|cfg_q)     mode = MODE_REGPD;
    else                 mode = MODE_RUN;
  end

  assign mode_o = mode;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NCH = 4
) (
  input logic           ref_clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic [NCH-1:0] cfg_wdata,
  input logic [NCH-1:0] cfg_q,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_oe,
  input logic [1:0]     mode_o
);
  // R9
  mode_legal_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mode_o != 2'b11);

  // R3
  oe_tracks_en_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ch_oe == ch_en);

  // R5
  loss_all_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> (ch_en == '0 && ch_oe == '0));

  // R2
  normal_all_on_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (ch_en == '1 && cfg_q == '0));

  // R4
  write_lands_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_wr && mode_o != 2'b10) |=> (cfg_q == $past(cfg_wdata)));

  // R6
  loss_retains_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> $stable(cfg_q));
endmodule

bind pwr_mode_ctrl pmc_checker #(.NCH(NCH)) chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .ch_en(ch_en), .ch_oe(ch_oe), .mode_o(mode_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int NCH     = 4;
  localparam int TIMEOUT = 400;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mclk = 1'b0;
  logic           mclk_run = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [NCH-1:0] cfg_wdata = '0;
  logic [NCH-1:0] cfg_q, ch_en, ch_oe;
  logic [1:0]     mode_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [NCH-1:0] exp_cfg = '0;

  always #4 clk = ~clk;

  initial forever begin
    #16;
    if (mclk_run) mclk = ~mclk;
  end

  pwr_mode_ctrl #(.NCH(NCH), .TIMEOUT(TIMEOUT)) dut_i (
    .ref_clk(ref_clk_w), .rst_n(rst_n), .mclk(mclk), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .ch_en(ch_en), .ch_oe(ch_oe),
    .mode_o(mode_o)
  );
  wire ref_clk_w = clk;

  function automatic logic [1:0] exp_mode(input logic alive, input logic [NCH-1:0] b);
    if (!alive)   return 2'b10;
    if (b != '0)  return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [NCH-1:0] exp_en(input logic alive, input logic [NCH-1:0] b);
    return alive ? ~b : '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic alive);
    check({req, " mode"}, 32'(mode_o), 32'(exp_mode(alive, exp_cfg)));
    check({req, " en"},   32'(ch_en),  32'(exp_en(alive, exp_cfg)));
    check({req, " oe"},   32'(ch_oe),  32'(exp_en(alive, exp_cfg)));
    check({req, " cfg"},  32'(cfg_q),  32'(exp_cfg));
  endtask

  task automatic write_cfg(input logic [NCH-1:0] d, input logic take);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (take) exp_cfg = d;
  endtask

  task automatic pulse_mclk();
    @(negedge clk); mclk = 1'b1;
    repeat (2) @(negedge clk);
    mclk = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2718));
    wait_cyc(5);
    check_state("R1 in reset", 1'b0);
    rst_n = 1'b1;
    wait_cyc(20);
    check_state("R1 after reset", 1'b0);

    // R6: write while clock lost is ignored
    write_cfg(4'hF, 1'b0);
    wait_cyc(2);
    check_state("R6 write in loss", 1'b0);

    // R8: isolated edges far apart do not recover
    pulse_mclk();
    wait_cyc(TIMEOUT + 20);
    pulse_mclk();
    wait_cyc(10);
    check_state("R8 lone edge", 1'b0);
    wait_cyc(TIMEOUT + 20);

    // R7: start clock, recover to normal
    mclk_run = 1'b1;
    wait_cyc(30);
    check_state("R7 recover normal", 1'b1);
    check_state("R2 normal", 1'b1);

    // R4 / R3: random writes under running clock
    for (int k = 0; k < 40; k++) begin
      logic [NCH-1:0] d;
      d = NCH'($urandom);
      if (k == 0) d = '0;
      if (k == 1) d = '1;
      if (k == 2) d = 4'b0101;
      write_cfg(d, 1'b1);
      check_state("R4 R3 random write", 1'b1);
    end

    // R5: stop clock with some bits set
    write_cfg(4'b0110, 1'b1);
    mclk_run = 1'b0;
    wait_cyc(TIMEOUT - 20);
    check_state("R5 before timeout", 1'b1);
    wait_cyc(40);
    check_state("R5 after timeout", 1'b0);

    // R6: retention and ignored write during loss
    write_cfg(4'b1001, 1'b0);
    wait_cyc(5);
    check_state("R6 retained", 1'b0);

    // R7: recover into register power-down per retained bits
    mclk_run = 1'b1;
    wait_cyc(30);
    check_state("R7 recover regpd", 1'b1);

    // R5: steady clock never trips
    wait_cyc(3 * TIMEOUT);
    check_state("R5 steady clock", 1'b1);

    // R1: reset clears register
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(3);
    exp_cfg = '0;
    check_state("R1 re-reset", 1'b0);
    rst_n = 1'b1;
    wait_cyc(30);
    check_state("R7 R2 after re-reset", 1'b1);
    check("R9 mode code", 32'(mode_o != 2'b11), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule